// File: doc/BRIEF.md
# USB Bus State and Speed Detector

This block watches the two USB data lines, sampled once per clock and already synchronized, during the gaps between packets. It works out whether the attached device idles at the full-speed or the low-speed level. It also times every interval in which both lines sit low (SE0). When such an interval ends, a long one is flagged as a bus reset and a medium one as a low-speed keep-alive. The bit receiver reads the speed result to choose its bit rate. Other logic reads the two single-cycle strobes.

The time base is the sample clock. Both duration limits are derived as sample counts from a frequency parameter. A two-bit mode input can pin the speed to full-speed or to low-speed, and the detected value is then ignored. Packet decoding and detach timing are handled elsewhere.

Top module: `usb_bus_state_det`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `spd_valid`, `spd_low`, `bus_reset_stb` and `keepalive_stb` are all 0.
- R2: In automatic mode (`mode_sel` 2'b00 or 2'b11), the speed stays unresolved (`spd_valid`=0) until the first sample with exactly one line high. D+=1, D-=0 then gives `spd_valid`=1, `spd_low`=0. D+=0, D-=1 gives `spd_valid`=1, `spd_low`=1. Once resolved, `spd_valid` stays 1 until reset.
- R3: `mode_sel`=2'b01 forces `spd_valid`=1, `spd_low`=0, and 2'b10 forces `spd_valid`=1, `spd_low`=1, one cycle after the mode is sampled, whatever the line levels.
- R4: An SE0 run's length is the number of consecutive samples with D+=0 and D-=0. It is judged on the first following sample that is not SE0, and any strobe it earns is high for exactly the one cycle after that sample.
- R5: A run longer than RST_LIM = floor(SAMPLE_HZ x 2.5 us) samples (120 at the default 48 MHz) pulses `bus_reset_stb`, in any mode.
- R6: A run longer than KA_LIM = floor(SAMPLE_HZ x 1.2 us) samples (57 at 48 MHz), but no longer than RST_LIM, pulses `keepalive_stb` only if `spd_low` is 1 at the moment the run is judged.
- R7: No keep-alive is flagged while `spd_low` is 0, and a run of KA_LIM samples or fewer raises no strobe.
- R8: A run of exactly one SE0 sample is ignored: it raises no strobe and does not re-detect the speed.
- R9: In automatic mode, the end of every SE0 run of two or more samples re-detects the speed from the level of the sample that ends it, if exactly one line is high in that sample.
- R10: `bus_reset_stb` and `keepalive_stb` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one line sample per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | 00/11 automatic, 01 forced full-speed, 10 forced low-speed |
| dp_smp | input | 1 | Synchronized D+ sample |
| dm_smp | input | 1 | Synchronized D- sample |
| spd_valid | output | 1 | Speed result is resolved |
| spd_low | output | 1 | 1 = low-speed, 0 = full-speed |
| bus_reset_stb | output | 1 | One-cycle pulse after a reset-length SE0 ends |
| keepalive_stb | output | 1 | One-cycle pulse after a keep-alive-length SE0 ends in low-speed |

## Verification
Every output is a register fed directly from the sample taken at a clock edge. So the speed result and both strobes for a given sample are due one clock after that sample, and a strobe for an SE0 run belongs to the sample that ends the run. The driver applies each sample on a falling edge and queues the values expected after the next rising edge. The monitor pops and compares one queue entry 1 ns after every rising edge, so each comparison lines up with its sample exactly. Run lengths of KA_LIM, KA_LIM+1, RST_LIM and RST_LIM+1 samples, a one-sample SE0, and mode changes within a sequence pin the boundaries to the cycle.

// File: rtl/usb_bsd_pkg.sv
package usb_bsd_pkg;

  typedef enum logic [1:0] {
    MODE_AUTO  = 2'b00,
    MODE_FS    = 2'b01,
    MODE_LS    = 2'b10,
    MODE_AUTO2 = 2'b11
  } spd_mode_e;

  typedef struct packed {
    logic se0;      // both lines low
    logic se1;      // both lines high
    logic fs_idle;  // D+ high, D- low
    logic ls_idle;  // D- high, D+ low
  } line_state_t;

  function automatic line_state_t decode_lines(input logic dp, input logic dm);
    line_state_t s;
    s.se0     = ~dp & ~dm;
    s.se1     =  dp &  dm;
    s.fs_idle =  dp & ~dm;
    s.ls_idle = ~dp &  dm;
    return s;
  endfunction

endpackage

// File: rtl/usb_bsd_se0_timer.sv
module usb_bsd_se0_timer #(
  parameter int RST_LIM = 120,
  parameter int KA_LIM  = 57
) (
  input  logic clk,
  input  logic rst,
  input  logic se0,
  output logic exit_qual,
  output logic len_rst,
  output logic len_ka
);
  localparam int CW = $clog2(RST_LIM + 2);
  localparam logic [CW-1:0] SAT   = CW'(RST_LIM + 1);
  localparam logic [CW-1:0] RST_L = CW'(RST_LIM);
  localparam logic [CW-1:0] KA_L  = CW'(KA_LIM);
  localparam logic [CW-1:0] ONE   = CW'(1);

  logic [CW-1:0] run_cnt;
  logic          prev_se0;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt  <= '0;
      prev_se0 <= 1'b0;
    end else begin
      prev_se0 <= se0;
      if (!se0)
        run_cnt <= '0;
      else if (!prev_se0)
        run_cnt <= ONE;
      else if (run_cnt != SAT)
        run_cnt <= run_cnt + ONE;
    end
  end

  always_comb begin
    exit_qual = ~se0 & prev_se0 & (run_cnt > ONE);
    len_rst   = run_cnt > RST_L;
    len_ka    = (run_cnt > KA_L) & ~len_rst;
  end

  AST_QUAL_NEEDS_TWO: assert property (@(posedge clk) disable iff (rst)
    exit_qual |-> ($past(se0) && $past(se0, 2))); // R8

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (run_cnt == SAT && se0) |=> (run_cnt == SAT || !$past(prev_se0))); // R5

endmodule

// File: rtl/usb_bsd_speed_track.sv
module usb_bsd_speed_track
  import usb_bsd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  spd_mode_e   mode,
  input  line_state_t lines,
  input  logic        exit_qual,
  output logic        spd_valid,
  output logic        spd_low
);
  logic det_vld, det_ls;
  logic det_vld_n, det_ls_n;
  logic upd;

  always_comb begin
    upd       = (lines.fs_idle | lines.ls_idle) & (~det_vld | exit_qual);
    det_vld_n = det_vld | upd;
    det_ls_n  = upd ? lines.ls_idle : det_ls;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      det_vld   <= 1'b0;
      det_ls    <= 1'b0;
      spd_valid <= 1'b0;
      spd_low   <= 1'b0;
    end else begin
      det_vld <= det_vld_n;
      det_ls  <= det_ls_n;
      unique case (mode)
        MODE_FS: begin spd_valid <= 1'b1;      spd_low <= 1'b0;     end
        MODE_LS: begin spd_valid <= 1'b1;      spd_low <= 1'b1;     end
        default: begin spd_valid <= det_vld_n; spd_low <= det_ls_n; end
      endcase
    end
  end

  AST_DET_STICKY: assert property (@(posedge clk) disable iff (rst)
    det_vld |=> det_vld); // R2

  AST_FORCED_FS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == MODE_FS) |-> (spd_valid && !spd_low)); // R3

  AST_FORCED_LS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == MODE_LS) |-> (spd_valid && spd_low)); // R3

endmodule

// File: rtl/usb_bus_state_det.sv
module usb_bus_state_det
  import usb_bsd_pkg::*;
#(
  parameter int SAMPLE_HZ = 48_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_sel,
  input  logic       dp_smp,
  input  logic       dm_smp,
  output logic       spd_valid,
  output logic       spd_low,
  output logic       bus_reset_stb,
  output logic       keepalive_stb
);
  // Limits in samples: floor(f * 2.5us) and floor(f * 1.2us)
  localparam int RST_LIM = int'((longint'(SAMPLE_HZ) * 25) / 64'd10_000_000);
  localparam int KA_LIM  = int'((longint'(SAMPLE_HZ) * 12) / 64'd10_000_000);

  line_state_t lines;
  logic exit_qual, len_rst, len_ka;

  assign lines = decode_lines(dp_smp, dm_smp);

  usb_bsd_se0_timer #(.RST_LIM(RST_LIM), .KA_LIM(KA_LIM)) timer_i (
    .clk       (clk),
    .rst       (rst),
    .se0       (lines.se0),
    .exit_qual (exit_qual),
    .len_rst   (len_rst),
    .len_ka    (len_ka)
  );

  usb_bsd_speed_track track_i (
    .clk       (clk),
    .rst       (rst),
    .mode      (spd_mode_e'(mode_sel)),
    .lines     (lines),
    .exit_qual (exit_qual),
    .spd_valid (spd_valid),
    .spd_low   (spd_low)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_reset_stb <= 1'b0;
      keepalive_stb <= 1'b0;
    end else begin
      bus_reset_stb <= exit_qual & len_rst;
      keepalive_stb <= exit_qual & len_ka & spd_low;
    end
  end

  AST_STB_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(bus_reset_stb && keepalive_stb)); // R10

  AST_RST_AFTER_SE0: assert property (@(posedge clk) disable iff (rst)
    bus_reset_stb |-> (($past(dp_smp) || $past(dm_smp)) &&
                       !$past(dp_smp, 2) && !$past(dm_smp, 2))); // R4

  AST_KA_NEEDS_LS: assert property (@(posedge clk) disable iff (rst)
    keepalive_stb |-> $past(spd_low)); // R6

  AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (bus_reset_stb || keepalive_stb) |=> !(bus_reset_stb || keepalive_stb)); // R4

endmodule

// File: tb/usb_bus_state_det_tb.sv
`timescale 1ns/1ps
module usb_bus_state_det_tb_top;

  localparam int RST_N = 120;
  localparam int KA_N  = 57;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_sel = 2'b00;
  logic       dp_smp = 1'b0;
  logic       dm_smp = 1'b0;
  logic       spd_valid, spd_low, bus_reset_stb, keepalive_stb;

  always #2 clk = ~clk; // 250 MHz

  usb_bus_state_det #(.SAMPLE_HZ(48_000_000)) dut_i (
    .clk           (clk),
    .rst           (rst),
    .mode_sel      (mode_sel),
    .dp_smp        (dp_smp),
    .dm_smp        (dm_smp),
    .spd_valid     (spd_valid),
    .spd_low       (spd_low),
    .bus_reset_stb (bus_reset_stb),
    .keepalive_stb (keepalive_stb)
  );

  typedef struct {
    logic  rs;
    logic  ka;
    logic  vld;
    logic  ls;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int   vectors = 0;
  int   misses  = 0;
  bit   done    = 1'b0;

  // Reference model state, built from the requirements
  logic m_prev = 1'b0, m_dvld = 1'b0, m_dls = 1'b0, m_out_ls = 1'b0;
  int   m_len = 0;

  // Monitor: compare one expected item 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      cur = q.pop_front();
      vectors++;
      if (bus_reset_stb !== cur.rs || keepalive_stb !== cur.ka ||
          spd_valid !== cur.vld || spd_low !== cur.ls) begin
        misses++;
        $display("FAIL %s: got rst=%b ka=%b vld=%b ls=%b, expected rst=%b ka=%b vld=%b ls=%b",
                 cur.tag, bus_reset_stb, keepalive_stb, spd_valid, spd_low,
                 cur.rs, cur.ka, cur.vld, cur.ls);
      end
    end
  end

  task automatic step(input logic p, input logic m, input logic [1:0] md, input string tag);
    logic se0, qual, rs, ka, vld, ls;
    @(negedge clk);
    dp_smp = p; dm_smp = m; mode_sel = md;
    se0  = !p && !m;
    qual = !se0 && m_prev && (m_len >= 2);
    rs   = qual && (m_len > RST_N);
    ka   = qual && !rs && (m_len > KA_N) && m_out_ls;
    if ((p ^ m) && (!m_dvld || qual)) begin
      m_dvld = 1'b1;
      m_dls  = m;
    end
    case (md)
      2'b01:   begin vld = 1'b1;   ls = 1'b0;  end
      2'b10:   begin vld = 1'b1;   ls = 1'b1;  end
      default: begin vld = m_dvld; ls = m_dls; end
    endcase
    m_len    = se0 ? (m_prev ? m_len + 1 : 1) : 0;
    m_prev   = se0;
    m_out_ls = ls;
    q.push_back('{rs, ka, vld, ls, tag});
  endtask

  task automatic se0_run(input int n, input logic p, input logic m,
                         input logic [1:0] md, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, md, "R4");
    step(p, m, md, tag);
  endtask

  task automatic idle(input int n, input logic p, input logic m,
                      input logic [1:0] md, input string tag);
    for (int i = 0; i < n; i++) step(p, m, md, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if (spd_valid !== 1'b0 || spd_low !== 1'b0 || bus_reset_stb !== 1'b0 || keepalive_stb !== 1'b0) begin
      misses++;
      $display("FAIL R1: got vld=%b ls=%b rst=%b ka=%b, expected all 0",
               spd_valid, spd_low, bus_reset_stb, keepalive_stb);
    end
    rst = 1'b0;
    // R1 / R2: unresolved while only SE1 seen
    idle(3, 1'b1, 1'b1, 2'b00, "R1");
    // R2: first full-speed idle level
    idle(4, 1'b1, 1'b0, 2'b00, "R2");
    // R5: reset boundaries in full-speed
    se0_run(130, 1'b1, 1'b0, 2'b00, "R5");
    idle(3, 1'b1, 1'b0, 2'b00, "R5");
    se0_run(RST_N, 1'b1, 1'b0, 2'b00, "R7");
    idle(2, 1'b1, 1'b0, 2'b00, "R7");
    se0_run(RST_N + 1, 1'b1, 1'b0, 2'b00, "R5");
    idle(2, 1'b1, 1'b0, 2'b00, "R5");
    // R7: keep-alive length while full-speed gives nothing
    se0_run(60, 1'b1, 1'b0, 2'b00, "R7");
    idle(2, 1'b1, 1'b0, 2'b00, "R7");
    // R9: reset then low-speed level re-detects
    se0_run(150, 1'b0, 1'b1, 2'b00, "R9");
    idle(3, 1'b0, 1'b1, 2'b00, "R9");
    // R6: keep-alive boundaries in low-speed
    se0_run(KA_N + 1, 1'b0, 1'b1, 2'b00, "R6");
    idle(2, 1'b0, 1'b1, 2'b00, "R6");
    se0_run(KA_N, 1'b0, 1'b1, 2'b00, "R7");
    idle(2, 1'b0, 1'b1, 2'b00, "R7");
    se0_run(RST_N, 1'b0, 1'b1, 2'b00, "R6");
    idle(2, 1'b0, 1'b1, 2'b00, "R10");
    // R8: single-sample SE0 ignored, no re-detect
    se0_run(1, 1'b1, 1'b0, 2'b00, "R8");
    idle(3, 1'b1, 1'b0, 2'b00, "R8");
    // R9: two-sample SE0 re-detects full-speed
    se0_run(2, 1'b1, 1'b0, 2'b00, "R9");
    idle(2, 1'b1, 1'b0, 2'b00, "R9");
    // R3: forced low-speed overrides full-speed level
    idle(3, 1'b1, 1'b0, 2'b10, "R3");
    se0_run(60, 1'b1, 1'b0, 2'b10, "R6");
    idle(2, 1'b1, 1'b0, 2'b10, "R3");
    // R3: forced full-speed with low-speed level
    idle(3, 1'b0, 1'b1, 2'b01, "R3");
    se0_run(60, 1'b0, 1'b1, 2'b01, "R7");
    se0_run(125, 1'b0, 1'b1, 2'b01, "R5");
    idle(2, 1'b0, 1'b1, 2'b01, "R3");
    // R2: alternate automatic code returns to detected value
    idle(3, 1'b0, 1'b1, 2'b11, "R2");
    se0_run(70, 1'b0, 1'b1, 2'b11, "R6");
    idle(3, 1'b0, 1'b1, 2'b11, "R10");
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule